// File: doc/BRIEF.md
# Watchdog Timer with Mode Register

This block is the watchdog of a small microcontroller. It counts pulses from a slow millisecond time base. If software does not refresh it in time, it raises a one-cycle chip reset request. The same request also pulls the chip out of STOP mode, so the watchdog doubles as a wake-up source with a bounded delay.

Software controls the block through a write-only 8-bit mode register. The register holds:
- a time-out code split into a coarse group (bits [6:4]) and a fine group (bits [1:0]);
- an enable that lets the counter keep running while the core is in HALT (bit 2);
- an enable that does the same in STOP (bit 3).

A power-on reset loads the register default. A stop-recovery reset clears only the counter and leaves the programmed configuration in place.

Top module: `wdog_unit`

## Requirements
- R1: After power-on reset, `rst_req` is low and the mode register holds 0x0D. The watchdog therefore times out after 10 ticks and keeps counting in both HALT and STOP.
- R2: With mode bits [6:4] = 000, bits [1:0] pick the time-out: 00 → 5 ticks, 01 → 10, 10 → 20, 11 → 80.
- R3: Mode bits [6:4] = 001 give 320 ticks, 010 give 1280 and 100 give 5120. Bits [1:0] are ignored in these cases.
- R4: If two or three of bits [6:4] are 1, the time-out is chosen by bits [1:0] alone, exactly as in R2.
- R5: When bit 2 is 0 and `halt_st` is high, ticks do not advance the counter. Bit 3 does the same for `stop_st`. When the matching bit is 1, counting continues in that state.
- R6: The Nth accepted tick after the counter was cleared (N = selected time-out) makes `rst_req` high for exactly one clock, in the cycle after that tick. The counter then restarts from zero.
- R7: A `kick` pulse clears the counter. A kick that arrives in the same cycle as a tick wins, and no time-out occurs in that cycle.
- R8: A write to the mode register clears the counter, so the new time-out is counted in full from the write.
- R9: A stop-recovery reset clears the counter and `rst_req` but leaves the mode register unchanged.
- R10: Bit 7 of written data is ignored. Writing 0x8C behaves exactly like writing 0x0C (5 ticks).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_por_n | input | 1 | Synchronous active-low power-on reset; resets everything |
| rst_smr_n | input | 1 | Synchronous active-low stop-recovery reset; resets the counter only |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| kick | input | 1 | Refresh pulse; clears the counter |
| halt_st | input | 1 | Core is in HALT |
| stop_st | input | 1 | Core is in STOP |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| rst_req | output | 1 | One-cycle chip reset and STOP wake-up request |

## Verification
The bench counts ticks up to the first reset request for every fine code, every coarse code and the fallback codes with several coarse bits set. A wrong decoder shows up as a wrong tick count, for example a fallback code read as a coarse period. It checks that a kick landing on the terminal tick suppresses the time-out; a design that let the tick win would fire one period early. It shows that a stop-recovery reset keeps a programmed 5-tick period, where a design that reset the register would show 10. It also shows that a low-power state with its enable cleared freezes the count instead of clearing it; a design that cleared the count would need a full period after the state ends.

// File: rtl/wdog_pkg.sv
// Package: shared mode-register layout and reset value for the watchdog.
// Assumes: the 8-bit register layout below is fixed by software.
package wdog_pkg;

    // Field layout of the mode register; positions are decoded by software.
    typedef struct packed {
        logic       rsvd;     // [7]   held at 0
        logic [2:0] coarse;   // [6:4] long time-out group
        logic       stop_en;  // [3]   run while in STOP
        logic       halt_en;  // [2]   run while in HALT
        logic [1:0] fine;     // [1:0] short time-out group
    } wdog_mode_t;

    localparam logic [7:0] MODE_RST = 8'h0D;

endpackage

// File: rtl/wdog_modereg.sv
// Module: wdog_modereg
// Holds the write-only mode register. Only power-on reset loads the default;
// the stop-recovery reset is deliberately not connected here.
// Assumes: cfg_we is a single-cycle strobe synchronous to clk.
module wdog_modereg
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_por_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [2:0] coarse,
    output logic [1:0] fine,
    output logic       halt_en,
    output logic       stop_en
);

    wdog_mode_t mode_q;
    logic       unused_rsvd;

    // Load the default on power-on reset; store writes with bit 7 forced to 0.
    always_ff @(posedge clk) begin
        if (!rst_por_n) begin
            mode_q <= wdog_mode_t'(MODE_RST);
        end else if (cfg_we) begin
            mode_q <= wdog_mode_t'({1'b0, cfg_wdata[6:0]});
        end
    end

    // Split the stored fields out to the decoder and the run gate.
    always_comb begin
        coarse  = mode_q.coarse;
        fine    = mode_q.fine;
        halt_en = mode_q.halt_en;
        stop_en = mode_q.stop_en;
    end

    assign unused_rsvd = mode_q.rsvd;

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        $past(cfg_we) |-> (fine == $past(cfg_wdata[1:0]) && coarse == $past(cfg_wdata[6:4])));

endmodule

// File: rtl/wdog_period.sv
// Module: wdog_period
// Turns the coarse and fine codes into the terminal count (time-out - 1).
// A coarse code with exactly one bit set picks a long period. Any other
// coarse code falls back to the fine table.
// Assumes: all periods are at least 1 and fit in CNT_W bits.
module wdog_period #(
    parameter int unsigned PER_F0 = 5,
    parameter int unsigned PER_F1 = 10,
    parameter int unsigned PER_F2 = 20,
    parameter int unsigned PER_F3 = 80,
    parameter int unsigned PER_C0 = 320,
    parameter int unsigned PER_C1 = 1280,
    parameter int unsigned PER_C2 = 5120,
    parameter int unsigned CNT_W  = 13
) (
    input  logic [2:0]       coarse,
    input  logic [1:0]       fine,
    output logic [CNT_W-1:0] term
);

    localparam int unsigned N_FINE   = 4;
    localparam int unsigned N_COARSE = 3;

    logic [CNT_W-1:0] fine_tbl   [N_FINE];
    logic [CNT_W-1:0] coarse_tbl [N_COARSE];

    // Build the terminal-count tables from the period parameters.
    always_comb begin
        fine_tbl[0]   = CNT_W'(PER_F0 - 1);
        fine_tbl[1]   = CNT_W'(PER_F1 - 1);
        fine_tbl[2]   = CNT_W'(PER_F2 - 1);
        fine_tbl[3]   = CNT_W'(PER_F3 - 1);
        coarse_tbl[0] = CNT_W'(PER_C0 - 1);
        coarse_tbl[1] = CNT_W'(PER_C1 - 1);
        coarse_tbl[2] = CNT_W'(PER_C2 - 1);
    end

    logic one_hot;
    assign one_hot = ($countones(coarse) == 1);

    // Select the long period when a single coarse bit is set, else the fine one.
    always_comb begin
        term = fine_tbl[fine];
        if (one_hot) begin
            for (int i = 0; i < N_COARSE; i++) begin
                if (coarse[i]) term = coarse_tbl[i];
            end
        end
    end

endmodule

// File: rtl/wdog_counter.sv
// Module: wdog_counter
// Tick counter and time-out pulse register. Either reset clears it. A clear
// request beats a tick in the same cycle. When a tick arrives with the count
// at term, the counter wraps to zero and fire is high for one cycle.
// Assumes: tick is a single-cycle enable; term is at least 1.
module wdog_counter #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_por_n,
    input  logic             rst_smr_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] term,
    output logic             fire
);

    logic [CNT_W-1:0] cnt_q;
    logic             any_rst;

    assign any_rst = !rst_por_n || !rst_smr_n;

    // Advance on accepted ticks; wrap and pulse fire at the terminal count.
    always_ff @(posedge clk) begin
        if (any_rst) begin
            cnt_q <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
            end else if (tick && run) begin
                if (cnt_q == term) begin
                    cnt_q <= '0;
                    fire  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R6
    fire_pulse_chk: assert property (@(posedge clk) disable iff (any_rst)
        fire |=> !fire);

    // R6
    fire_cause_chk: assert property (@(posedge clk) disable iff (any_rst)
        fire |-> $past(tick && run && !clr));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (any_rst)
        (!run && !clr) |=> (cnt_q == $past(cnt_q)));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (any_rst)
        clr |=> (cnt_q == '0 && !fire));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (any_rst)
        cnt_q <= term);

endmodule

// File: rtl/wdog_unit.sv
// Module: wdog_unit (top)
// Watchdog timer. It contains the mode register, the period decoder and the
// tick counter. A kick or a register write clears the counter. The HALT and
// STOP enables gate the ticks.
// Assumes: all inputs are synchronous to clk; tick_ms is a one-cycle pulse.
module wdog_unit #(
    parameter int unsigned PER_F0 = 5,
    parameter int unsigned PER_F1 = 10,
    parameter int unsigned PER_F2 = 20,
    parameter int unsigned PER_F3 = 80,
    parameter int unsigned PER_C0 = 320,
    parameter int unsigned PER_C1 = 1280,
    parameter int unsigned PER_C2 = 5120
) (
    input  logic       clk,
    input  logic       rst_por_n,
    input  logic       rst_smr_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       kick,
    input  logic       halt_st,
    input  logic       stop_st,
    input  logic       tick_ms,
    output logic       rst_req
);

    // The longest period is assumed to be the last coarse one.
    localparam int unsigned CNT_W = $clog2(PER_C2 + 1);

    logic [2:0]       coarse;
    logic [1:0]       fine;
    logic             halt_en;
    logic             stop_en;
    logic [CNT_W-1:0] term;
    logic             run;
    logic             clr;

    wdog_modereg u_mode (
        .clk       (clk),
        .rst_por_n (rst_por_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .coarse    (coarse),
        .fine      (fine),
        .halt_en   (halt_en),
        .stop_en   (stop_en)
    );

    wdog_period #(
        .PER_F0 (PER_F0), .PER_F1 (PER_F1), .PER_F2 (PER_F2), .PER_F3 (PER_F3),
        .PER_C0 (PER_C0), .PER_C1 (PER_C1), .PER_C2 (PER_C2), .CNT_W (CNT_W)
    ) u_period (
        .coarse (coarse),
        .fine   (fine),
        .term   (term)
    );

    // Tick gate: a low-power state whose enable is clear freezes the count.
    always_comb begin
        run = !(halt_st && !halt_en) && !(stop_st && !stop_en);
        clr = kick || cfg_we;
    end

    wdog_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_por_n (rst_por_n),
        .rst_smr_n (rst_smr_n),
        .clr       (clr),
        .tick      (tick_ms),
        .run       (run),
        .term      (term),
        .fire      (rst_req)
    );

    // R1
    por_quiet_chk: assert property (@(posedge clk)
        !rst_por_n |=> !rst_req);

endmodule

// File: tb/test_wdog_unit.sv
`timescale 1ns/1ps
// Directed bench for wdog_unit. Each scenario task checks its own results.
module test_wdog_unit;

    logic       clk = 1'b0;
    logic       rst_por_n = 1'b0;
    logic       rst_smr_n = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       kick = 1'b0;
    logic       halt_st = 1'b0;
    logic       stop_st = 1'b0;
    logic       tick_ms = 1'b0;
    logic       rst_req;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    wdog_unit i_wdog_unit (
        .clk (clk), .rst_por_n (rst_por_n), .rst_smr_n (rst_smr_n),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .kick (kick),
        .halt_st (halt_st), .stop_st (stop_st), .tick_ms (tick_ms),
        .rst_req (rst_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected time-out in ticks, taken from the requirement text.
    function automatic int exp_period(input logic [7:0] m);
        case (m[6:4])
            3'b001: return 320;
            3'b010: return 1280;
            3'b100: return 5120;
            default: case (m[1:0])
                2'b00: return 5;
                2'b01: return 10;
                2'b10: return 20;
                default: return 80;
            endcase
        endcase
    endfunction

    task automatic wr(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One tick; rst_req is sampled at the next negedge.
    task automatic tick_once(output logic fired);
        tick_ms = 1'b1;
        @(negedge clk);
        tick_ms = 1'b0;
        fired = rst_req;
    endtask

    // Ticks until the first time-out, up to limit; n = index or 0 if none.
    task automatic run_to_fire(input int limit, output int n);
        logic f;
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            tick_once(f);
            if (f) begin
                n = i;
                break;
            end
        end
        @(negedge clk);
    endtask

    task automatic por();
        rst_por_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_por_n = 1'b1;
    endtask

    task automatic t_reset();
        int n;
        por();
        chk(rst_req == 1'b0, "R1 rst_req after reset", int'(rst_req), 0);
        run_to_fire(40, n);
        chk(n == 10, "R1 default period", n, 10);
        halt_st = 1'b1; stop_st = 1'b1;
        run_to_fire(40, n);
        chk(n == 10, "R1 default runs in HALT+STOP", n, 10);
        halt_st = 1'b0; stop_st = 1'b0;
    endtask

    task automatic t_codes(input logic [7:0] m, input string req);
        int n;
        int e;
        e = exp_period(m);
        wr(m);
        run_to_fire(e + 10, n);
        chk(n == e, req, n, e);
    endtask

    task automatic t_pulse();
        int n;
        wr(8'h0C);
        run_to_fire(20, n);
        chk(rst_req == 1'b0, "R6 pulse lasts one cycle", int'(rst_req), 0);
        run_to_fire(20, n);
        chk(n == 5, "R6 counter restarts after time-out", n, 5);
    endtask

    task automatic t_lowpower();
        int n;
        // bit2 = 0: HALT freezes
        wr(8'h08);
        run_to_fire(3, n);
        chk(n == 0, "R5 no early fire", n, 0);
        halt_st = 1'b1;
        run_to_fire(20, n);
        chk(n == 0, "R5 frozen in HALT", n, 0);
        halt_st = 1'b0;
        run_to_fire(10, n);
        chk(n == 2, "R5 count held across HALT", n, 2);
        wr(8'h0C); halt_st = 1'b1;
        run_to_fire(10, n);
        chk(n == 5, "R5 runs in HALT when enabled", n, 5);
        halt_st = 1'b0;
        // bit3 = 0: STOP freezes
        wr(8'h04);
        run_to_fire(3, n);
        stop_st = 1'b1;
        run_to_fire(20, n);
        chk(n == 0, "R5 frozen in STOP", n, 0);
        stop_st = 1'b0;
        run_to_fire(10, n);
        chk(n == 2, "R5 count held across STOP", n, 2);
        wr(8'h0C); stop_st = 1'b1;
        run_to_fire(10, n);
        chk(n == 5, "R5 runs in STOP when enabled", n, 5);
        stop_st = 1'b0;
    endtask

    task automatic t_kick();
        int n;
        wr(8'h0C);
        run_to_fire(4, n);
        kick = 1'b1; @(negedge clk); kick = 1'b0;
        run_to_fire(10, n);
        chk(n == 5, "R7 kick clears counter", n, 5);
        run_to_fire(4, n);
        kick = 1'b1; tick_ms = 1'b1;
        @(negedge clk);
        kick = 1'b0; tick_ms = 1'b0;
        chk(rst_req == 1'b0, "R7 kick beats terminal tick", int'(rst_req), 0);
        @(negedge clk);
        run_to_fire(10, n);
        chk(n == 5, "R7 full period after kick", n, 5);
    endtask

    task automatic t_write();
        int n;
        wr(8'h0E);
        run_to_fire(15, n);
        chk(n == 0, "R8 no fire before write", n, 0);
        wr(8'h0C);
        run_to_fire(10, n);
        chk(n == 5, "R8 write restarts count", n, 5);
    endtask

    task automatic t_smr();
        int n;
        wr(8'h0C);
        run_to_fire(3, n);
        rst_smr_n = 1'b0; @(negedge clk); rst_smr_n = 1'b1;
        chk(rst_req == 1'b0, "R9 rst_req low after stop recovery", int'(rst_req), 0);
        run_to_fire(20, n);
        chk(n == 5, "R9 mode kept, counter cleared", n, 5);
        por();
        run_to_fire(20, n);
        chk(n == 10, "R1 power-on reset restores default", n, 10);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL WATCHDOG: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_codes(8'h0C, "R2 fine 00");
        t_codes(8'h0D, "R2 fine 01");
        t_codes(8'h0E, "R2 fine 10");
        t_codes(8'h0F, "R2 fine 11");
        t_codes(8'h1F, "R3 coarse 001");
        t_codes(8'h2C, "R3 coarse 010");
        t_codes(8'h4D, "R3 coarse 100");
        t_codes(8'h3E, "R4 fallback 011");
        t_codes(8'h7C, "R4 fallback 111");
        t_codes(8'h5F, "R4 fallback 101");
        t_codes(8'h6D, "R4 fallback 110");
        t_codes(8'h8C, "R10 bit7 ignored");
        t_codes(8'hFF, "R10 bit7 with fallback");
        t_pulse();
        t_lowpower();
        t_kick();
        t_write();
        t_smr();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule